// File: doc/BRIEF.md
# Binary64 Rounding and Exception Stage

This stage is the back end of a double-precision arithmetic pipeline. An upstream datapath hands it a normalized 53-bit significand with the hidden bit set, a signed intermediate exponent that may lie outside the representable range, the result sign, a guard bit and a sticky bit. The stage also takes the rounding mode, four trap enables and an invalid-operation marker. It returns the final 64-bit word, the exception flags and a trap vector. The output is registered, so it appears one cycle after the operands are taken.

In the representable range the stage rounds the value once. When the value is too large it either clamps the result to infinity or to the largest finite magnitude, or, with the overflow trap enabled, returns the result with its exponent wrapped down. When the value is too small it either denormalizes and rounds a second time, or, with the underflow trap enabled, returns it with its exponent wrapped up. Tininess is judged after rounding. To do this the stage rounds a trial copy of the value with no exponent bound whenever the exponent sits exactly at zero.

Top module: `frnd_unit`

## Requirements
- R1: The outputs are registered. `out_valid` is high exactly one cycle after a cycle with `in_valid` high. While reset is active, every output is zero.
- R2: An exact value with exponent in 1..2046 is returned unchanged: the sign, the low 11 exponent bits and the 52 fraction bits. No flag and no trap is raised.
- R3: Rounding-mode encoding is 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf. In nearest-even the fraction is incremented when guard is set and either sticky or the fraction LSB is set.
- R4: Toward zero never increments. Toward +inf increments only positive inexact values, and toward -inf increments only negative inexact values.
- R5: Rounding is applied when the value is inexact and either the exponent is above 0 or the underflow trap is enabled. A carry out of the fraction raises the exponent by one, and the overflow test uses this raised exponent.
- R6: When the rounded exponent is 2047 or more and the overflow trap is disabled, the overflow and inexact flags are set. The result is infinity in nearest-even mode, in toward +inf mode for a positive sign, and in toward -inf mode for a negative sign. In every other case the result is the largest finite value of that sign.
- R7: With the overflow trap enabled, an overflowed result keeps its rounded fraction, and its exponent is reduced by 1536. The overflow trap bit is raised and the overflow flag is not.
- R8: With the underflow trap enabled, a rounded exponent of 0 or less is raised by 1536 and the underflow trap bit is raised. A value that rounds up to exponent 1 is not an underflow.
- R9: With the underflow trap disabled and exponent e ≤ 0, the significand is shifted right by 1-e. The shifted-out bits form the new guard and sticky, the incoming guard and sticky bits are folded into the sticky, and the value is rounded again. The 63-bit magnitude field is the rounded significand, so a carry reaches exponent field 1. A shift of 54 or more yields only zero or the smallest subnormal.
- R10: Tininess is decided after rounding. At exponent 0 with an inexact input, if trial rounding of the normalized value carries out of the binade, the value is not tiny.
- R11: With the underflow trap disabled, the underflow flag is set only when the value is tiny and the denormalized result is inexact. An exact subnormal raises nothing.
- R12: Flag and trap bit positions are: 0 inexact, 1 underflow, 2 overflow, 3 invalid. The trap-enable input uses the same positions. An inexact final result sets the inexact trap bit if that trap is enabled, and otherwise sets the inexact flag. The inexact flag and the inexact trap are never set together.
- R13: With `in_invalid` high, the result is the default quiet NaN 0x7FF8000000000000 and no other exception is reported. The invalid trap bit is raised if that trap is enabled, and otherwise the invalid flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | IEXP_W | Biased intermediate exponent, two's complement |
| in_sig | input | FRAC_W+1 | Normalized significand, hidden bit at the top |
| in_guard | input | 1 | First bit below the significand LSB |
| in_sticky | input | 1 | OR of all lower discarded bits |
| in_invalid | input | 1 | Upstream detected an invalid operation |
| in_rmode | input | 2 | Rounding mode |
| in_trap_en | input | 4 | Trap enables (inexact, underflow, overflow, invalid) |
| out_valid | output | 1 | Result present |
| out_result | output | 1+EXP_W+FRAC_W | Final floating-point word |
| out_flags | output | 4 | Exception flags raised without a trap |
| out_trap | output | 4 | Trap vector, one or more bits |

## Verification
The assertions assume three things about the inputs. The significand arrives with its top bit set, the rounding mode and trap enables are held steady for the cycle they are sampled, and the intermediate exponent is small enough that a wrapped result never lands on the all-ones exponent. The stimulus table uses only normalized significands and exponents between -60 and 3000. This keeps every wrapped exponent between 511 and 1536. The denormalization boundaries get their own cases: shifts of 52, 53 and more than 54; exponent 0 with an all-ones significand under each tininess outcome; and a carry that lifts an underflow-trapped value back into range.

// File: rtl/frnd_pkg.sv
`timescale 1ns/1ps
package frnd_pkg;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_UP   = 2'd2,
      RM_DOWN = 2'd3
   } frnd_mode_e;

   // exception bit positions shared by flags, traps and trap enables
   localparam int XI_INX = 0;
   localparam int XI_UNF = 1;
   localparam int XI_OVF = 2;
   localparam int XI_INV = 3;
   localparam int XI_N   = 4;

   // decide whether the kept part moves one unit away from zero
   function automatic logic rnd_up(frnd_mode_e mode, logic sign, logic lsb,
                                   logic g, logic s);
      logic r;
      case (mode)
         RM_NEAR: r = g & (s | lsb);
         RM_UP:   r = ~sign & (g | s);
         RM_DOWN: r = sign & (g | s);
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/frnd_incr.sv
`timescale 1ns/1ps
module frnd_incr
   import frnd_pkg::*;
#(
   parameter int W = 52
) (
   input  frnd_mode_e   mode,
   input  logic         sign,
   input  logic         en,
   input  logic         g,
   input  logic         s,
   input  logic [W-1:0] sig,
   output logic [W:0]   nxt
);
   logic bump;

   always_comb begin
      bump = en & rnd_up(mode, sign, sig[0], g, s);
      nxt  = {1'b0, sig} + {{W{1'b0}}, bump};
   end
endmodule

// File: rtl/frnd_denorm.sv
`timescale 1ns/1ps
module frnd_denorm #(
   parameter int SIG_W  = 53,
   parameter int SH_MAX = SIG_W + 2,
   parameter int SH_W   = $clog2(SH_MAX + 1)
) (
   input  logic [SIG_W-1:0] sig,
   input  logic             g_in,
   input  logic             s_in,
   input  logic [SH_W-1:0]  sh,
   output logic [SIG_W-1:0] frac,
   output logic             g_out,
   output logic             s_out
);
   localparam int EXT_W = SIG_W + SH_MAX;

   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] shifted;

   always_comb begin
      ext     = {sig, {SH_MAX{1'b0}}};
      shifted = ext >> sh;
      frac    = shifted[EXT_W-1 -: SIG_W];
      g_out   = shifted[SH_MAX-1];
      s_out   = (|shifted[SH_MAX-2:0]) | g_in | s_in;
   end
endmodule

// File: rtl/frnd_ovf_pick.sv
`timescale 1ns/1ps
module frnd_ovf_pick
   import frnd_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  frnd_mode_e               mode,
   input  logic                     sign,
   output logic [EXP_W+FRAC_W:0]    word
);
   logic to_inf;

   always_comb begin
      to_inf = (mode == RM_NEAR) |
               ((mode == RM_UP)   & ~sign) |
               ((mode == RM_DOWN) &  sign);
      if (to_inf)
         word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
         word = {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
   end
endmodule

// File: rtl/frnd_unit.sv
`timescale 1ns/1ps
module frnd_unit
   import frnd_pkg::*;
#(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter int IEXP_W  = 14,
   parameter int OUT_REG = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      in_sign,
   input  logic [IEXP_W-1:0]         in_exp,
   input  logic [FRAC_W:0]           in_sig,
   input  logic                      in_guard,
   input  logic                      in_sticky,
   input  logic                      in_invalid,
   input  logic [1:0]                in_rmode,
   input  logic [3:0]                in_trap_en,
   output logic                      out_valid,
   output logic [EXP_W+FRAC_W:0]     out_result,
   output logic [3:0]                out_flags,
   output logic [3:0]                out_trap
);
   localparam int SIG_W  = FRAC_W + 1;
   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam int EMAX   = (1 << EXP_W) - 1;
   localparam int WRAP   = 3 << (EXP_W - 2);
   localparam int SH_MAX = SIG_W + 2;
   localparam int SH_W   = $clog2(SH_MAX + 1);
   localparam int XW     = IEXP_W + 2;

   localparam logic [WORD_W-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   // elaboration-time parameter checks
   if (EXP_W < 3) begin : g_bad_exp
      $error("frnd_unit: EXP_W must be at least 3");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("frnd_unit: FRAC_W must be at least 2");
   end
   if (IEXP_W < EXP_W + 2) begin : g_bad_iexp
      $error("frnd_unit: IEXP_W must exceed EXP_W by 2");
   end

   frnd_mode_e mode;
   logic signed [XW-1:0] ex;
   logic signed [XW-1:0] er;
   logic signed [XW-1:0] er_ovw;
   logic signed [XW-1:0] er_unw;
   logic signed [XW-1:0] sh_full;
   logic [SH_W-1:0]      sh;
   logic                 in_inexact;
   logic                 nrm_en;
   logic [FRAC_W:0]      nxt_n;
   logic                 trial_en;
   logic                 tiny;
   logic                 ovf;
   logic                 unf;
   logic [SIG_W-1:0]     dn_frac;
   logic                 dn_g;
   logic                 dn_s;
   logic                 dn_inexact;
   logic [SIG_W:0]       dn_nxt;
   logic [WORD_W-1:0]    ovf_word;

   logic [WORD_W-1:0]    res_c;
   logic [3:0]           flg_c;
   logic [3:0]           trp_c;
   logic                 inx_c;

   assign mode       = frnd_mode_e'(in_rmode);
   assign ex         = XW'($signed(in_exp));
   assign in_inexact = in_guard | in_sticky;
   assign nrm_en     = in_inexact & ((ex > 0) | in_trap_en[XI_UNF]);

   // normal-range rounding acts on the fraction; its carry is the binade step
   frnd_incr #(.W(FRAC_W)) u_rnd_norm (
      .mode (mode),
      .sign (in_sign),
      .en   (nrm_en),
      .g    (in_guard),
      .s    (in_sticky),
      .sig  (in_sig[FRAC_W-1:0]),
      .nxt  (nxt_n)
   );

   assign er     = ex + XW'(nxt_n[FRAC_W]);
   assign er_ovw = er - XW'(WRAP);
   assign er_unw = er + XW'(WRAP);
   assign ovf    = (er >= XW'(EMAX));
   assign unf    = (er <= 0);

   // tininess after rounding: trial increment with an unbounded exponent
   assign trial_en = in_inexact & (ex == 0);
   assign tiny     = ~(trial_en & (&in_sig) &
                       rnd_up(mode, in_sign, in_sig[0], in_guard, in_sticky));

   // denormalization shift amount, saturated once everything is sticky
   assign sh_full = XW'(1) - ex;
   assign sh      = (sh_full > XW'(SH_MAX)) ? SH_W'(SH_MAX) : sh_full[SH_W-1:0];

   frnd_denorm #(.SIG_W(SIG_W), .SH_MAX(SH_MAX), .SH_W(SH_W)) u_denorm (
      .sig   (in_sig),
      .g_in  (in_guard),
      .s_in  (in_sticky),
      .sh    (sh),
      .frac  (dn_frac),
      .g_out (dn_g),
      .s_out (dn_s)
   );

   assign dn_inexact = dn_g | dn_s;

   frnd_incr #(.W(SIG_W)) u_rnd_sub (
      .mode (mode),
      .sign (in_sign),
      .en   (dn_inexact),
      .g    (dn_g),
      .s    (dn_s),
      .sig  (dn_frac),
      .nxt  (dn_nxt)
   );

   frnd_ovf_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ovf (
      .mode (mode),
      .sign (in_sign),
      .word (ovf_word)
   );

   // exception resolution
   always_comb begin
      res_c = {in_sign, er[EXP_W-1:0], nxt_n[FRAC_W-1:0]};
      flg_c = '0;
      trp_c = '0;
      inx_c = in_inexact;
      if (in_invalid) begin
         res_c = QNAN;
         inx_c = 1'b0;
         if (in_trap_en[XI_INV]) trp_c[XI_INV] = 1'b1;
         else                    flg_c[XI_INV] = 1'b1;
      end else if (ovf) begin
         if (in_trap_en[XI_OVF]) begin
            res_c = {in_sign, er_ovw[EXP_W-1:0], nxt_n[FRAC_W-1:0]};
            trp_c[XI_OVF] = 1'b1;
         end else begin
            res_c = ovf_word;
            flg_c[XI_OVF] = 1'b1;
            inx_c = 1'b1;
         end
      end else if (unf) begin
         if (in_trap_en[XI_UNF]) begin
            res_c = {in_sign, er_unw[EXP_W-1:0], nxt_n[FRAC_W-1:0]};
            trp_c[XI_UNF] = 1'b1;
         end else begin
            res_c = {in_sign, {(EXP_W-2){1'b0}}, dn_nxt};
            inx_c = dn_inexact;
            if (dn_inexact & tiny) flg_c[XI_UNF] = 1'b1;
         end
      end
      if (inx_c) begin
         if (in_trap_en[XI_INX]) trp_c[XI_INX] = 1'b1;
         else                    flg_c[XI_INX] = 1'b1;
      end
   end

   if (OUT_REG != 0) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
            out_trap   <= '0;
         end else begin
            out_valid  <= in_valid;
            out_result <= in_valid ? res_c : '0;
            out_flags  <= in_valid ? flg_c : '0;
            out_trap   <= in_valid ? trp_c : '0;
         end
      end
   end else begin : g_comb
      assign out_valid  = in_valid;
      assign out_result = in_valid ? res_c : '0;
      assign out_flags  = in_valid ? flg_c : '0;
      assign out_trap   = in_valid ? trp_c : '0;
   end

endmodule

// File: rtl/frnd_unit_chk.sv
`timescale 1ns/1ps
module frnd_unit_chk
   import frnd_pkg::*;
#(
   parameter int EXP_W   = 11,
   parameter int REG_OUT = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_rmode,
   input logic             out_valid,
   input logic [EXP_W-1:0] res_exp,
   input logic [3:0]       out_flags,
   input logic [3:0]       out_trap
);
   if (REG_OUT != 0) begin : g_lat
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);                                     // R1
      AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);                                   // R1
      AST_RZ_OVF_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_flags[XI_OVF] && $past(in_rmode) == RM_ZERO)
         |-> res_exp != {EXP_W{1'b1}});                               // R6
   end

   AST_OVF_FLAG_OR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_flags[XI_OVF] && out_trap[XI_OVF]));        // R7
   AST_INX_FLAG_OR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_flags[XI_INX] && out_trap[XI_INX]));        // R12
   AST_UNF_NEEDS_INX: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[XI_UNF]) |->
      (out_flags[XI_INX] || out_trap[XI_INX]));                       // R11
   AST_NO_SPURIOUS_INF: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_trap[XI_OVF] && !out_trap[XI_UNF] &&
       res_exp == {EXP_W{1'b1}}) |->
      (out_flags[XI_OVF] || out_flags[XI_INV] || out_trap[XI_INV]));  // R6
endmodule

bind frnd_unit frnd_unit_chk #(.EXP_W(EXP_W), .REG_OUT(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_rmode  (in_rmode),
   .out_valid (out_valid),
   .res_exp   (out_result[EXP_W+FRAC_W-1 -: EXP_W]),
   .out_flags (out_flags),
   .out_trap  (out_trap)
);

// File: tb/tb_frnd_unit.sv
`timescale 1ns/1ps
module tb_frnd_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sign = 1'b0;
   logic [13:0] in_exp = '0;
   logic [52:0] in_sig = '0;
   logic        in_guard = 1'b0;
   logic        in_sticky = 1'b0;
   logic        in_invalid = 1'b0;
   logic [1:0]  in_rmode = '0;
   logic [3:0]  in_trap_en = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic [3:0]  out_flags;
   logic [3:0]  out_trap;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   frnd_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard),
      .in_sticky(in_sticky), .in_invalid(in_invalid), .in_rmode(in_rmode),
      .in_trap_en(in_trap_en), .out_valid(out_valid),
      .out_result(out_result), .out_flags(out_flags), .out_trap(out_trap)
   );

   typedef struct packed {
      logic        sg;
      logic [13:0] ex;
      logic [52:0] sig;
      logic        g;
      logic        s;
      logic        inv;
      logic [1:0]  rm;
      logic [3:0]  ten;
      logic [63:0] res;
      logic [3:0]  fl;
      logic [3:0]  tr;
      logic [3:0]  req;
   } vec_t;

   localparam logic [52:0] M1 = 53'h10000000000000;
   localparam logic [52:0] MO = 53'h10000000000001;
   localparam logic [52:0] MA = 53'h1FFFFFFFFFFFFF;
   localparam int NV = 33;

   // rm: 0 near, 1 zero, 2 up, 3 down; flag/trap bits: 0 inx 1 unf 2 ovf 3 inv
   localparam vec_t VTAB [NV] = '{
      '{1'b0, 14'sd1023, M1, 1'b0,1'b0,1'b0, 2'd0, 4'h0, 64'h3FF0000000000000, 4'h0, 4'h0, 4'd2},  // R2
      '{1'b0, 14'sd1023, M1, 1'b1,1'b0,1'b0, 2'd0, 4'h0, 64'h3FF0000000000000, 4'h1, 4'h0, 4'd3},  // R3 tie even
      '{1'b0, 14'sd1023, MO, 1'b1,1'b0,1'b0, 2'd0, 4'h0, 64'h3FF0000000000002, 4'h1, 4'h0, 4'd3},  // R3 tie odd
      '{1'b0, 14'sd1023, M1, 1'b1,1'b1,1'b0, 2'd0, 4'h0, 64'h3FF0000000000001, 4'h1, 4'h0, 4'd3},  // R3
      '{1'b0, 14'sd1023, MA, 1'b1,1'b1,1'b0, 2'd1, 4'h0, 64'h3FFFFFFFFFFFFFFF, 4'h1, 4'h0, 4'd4},  // R4
      '{1'b0, 14'sd1023, MA, 1'b0,1'b1,1'b0, 2'd2, 4'h0, 64'h4000000000000000, 4'h1, 4'h0, 4'd5},  // R5
      '{1'b1, 14'sd1023, M1, 1'b1,1'b0,1'b0, 2'd2, 4'h0, 64'hBFF0000000000000, 4'h1, 4'h0, 4'd4},  // R4
      '{1'b1, 14'sd1023, M1, 1'b0,1'b1,1'b0, 2'd3, 4'h0, 64'hBFF0000000000001, 4'h1, 4'h0, 4'd4},  // R4
      '{1'b0, 14'sd1023, M1, 1'b0,1'b1,1'b0, 2'd3, 4'h0, 64'h3FF0000000000000, 4'h1, 4'h0, 4'd4},  // R4
      '{1'b0, 14'sd2047, M1, 1'b0,1'b0,1'b0, 2'd0, 4'h0, 64'h7FF0000000000000, 4'h5, 4'h0, 4'd6},  // R6
      '{1'b1, 14'sd3000, M1, 1'b0,1'b0,1'b0, 2'd1, 4'h0, 64'hFFEFFFFFFFFFFFFF, 4'h5, 4'h0, 4'd6},  // R6
      '{1'b0, 14'sd2500, M1, 1'b0,1'b0,1'b0, 2'd3, 4'h0, 64'h7FEFFFFFFFFFFFFF, 4'h5, 4'h0, 4'd6},  // R6
      '{1'b1, 14'sd2500, M1, 1'b0,1'b0,1'b0, 2'd3, 4'h0, 64'hFFF0000000000000, 4'h5, 4'h0, 4'd6},  // R6
      '{1'b0, 14'sd2046, MA, 1'b1,1'b0,1'b0, 2'd0, 4'h0, 64'h7FF0000000000000, 4'h5, 4'h0, 4'd5},  // R5
      '{1'b0, 14'sd2047, M1, 1'b0,1'b0,1'b0, 2'd0, 4'h4, 64'h1FF0000000000000, 4'h0, 4'h4, 4'd7},  // R7
      '{1'b0, 14'sd2100, M1, 1'b1,1'b0,1'b0, 2'd0, 4'h4, 64'h2340000000000000, 4'h1, 4'h4, 4'd7},  // R7
      '{1'b0, 14'sd2100, M1, 1'b1,1'b0,1'b0, 2'd0, 4'h5, 64'h2340000000000000, 4'h0, 4'h5, 4'd7},  // R7
      '{1'b0, 14'sd0,    M1, 1'b0,1'b0,1'b0, 2'd0, 4'h2, 64'h6000000000000000, 4'h0, 4'h2, 4'd8},  // R8
      '{1'b1, -14'sd10,  M1, 1'b0,1'b0,1'b0, 2'd0, 4'h2, 64'hDF60000000000000, 4'h0, 4'h2, 4'd8},  // R8
      '{1'b0, 14'sd0,    MA, 1'b1,1'b0,1'b0, 2'd0, 4'h2, 64'h0010000000000000, 4'h1, 4'h0, 4'd8},  // R8
      '{1'b0, 14'sd0,    M1, 1'b0,1'b0,1'b0, 2'd0, 4'h0, 64'h0008000000000000, 4'h0, 4'h0, 4'd9},  // R9
      '{1'b0, -14'sd51,  M1, 1'b0,1'b0,1'b0, 2'd0, 4'h0, 64'h0000000000000001, 4'h0, 4'h0, 4'd9},  // R9
      '{1'b0, -14'sd52,  M1, 1'b0,1'b0,1'b0, 2'd0, 4'h0, 64'h0000000000000000, 4'h3, 4'h0, 4'd9},  // R9
      '{1'b0, -14'sd52,  M1, 1'b0,1'b0,1'b0, 2'd2, 4'h0, 64'h0000000000000001, 4'h3, 4'h0, 4'd9},  // R9
      '{1'b0, -14'sd60,  M1, 1'b0,1'b0,1'b0, 2'd0, 4'h0, 64'h0000000000000000, 4'h3, 4'h0, 4'd9},  // R9
      '{1'b1, -14'sd60,  M1, 1'b0,1'b0,1'b0, 2'd3, 4'h0, 64'h8000000000000001, 4'h3, 4'h0, 4'd9},  // R9
      '{1'b0, 14'sd0,    MA, 1'b1,1'b0,1'b0, 2'd0, 4'h0, 64'h0010000000000000, 4'h1, 4'h0, 4'd10}, // R10
      '{1'b0, 14'sd0,    MA, 1'b1,1'b0,1'b0, 2'd1, 4'h0, 64'h000FFFFFFFFFFFFF, 4'h3, 4'h0, 4'd10}, // R10
      '{1'b0, 14'sd0,    MA, 1'b0,1'b0,1'b0, 2'd0, 4'h0, 64'h0010000000000000, 4'h3, 4'h0, 4'd11}, // R11
      '{1'b0, -14'sd52,  M1, 1'b0,1'b0,1'b0, 2'd0, 4'h1, 64'h0000000000000000, 4'h2, 4'h1, 4'd12}, // R12
      '{1'b0, 14'sd1023, M1, 1'b1,1'b1,1'b0, 2'd0, 4'h1, 64'h3FF0000000000001, 4'h0, 4'h1, 4'd12}, // R12
      '{1'b0, 14'sd1023, M1, 1'b0,1'b0,1'b1, 2'd0, 4'h0, 64'h7FF8000000000000, 4'h8, 4'h0, 4'd13}, // R13
      '{1'b0, 14'sd1023, M1, 1'b1,1'b1,1'b1, 2'd0, 4'h8, 64'h7FF8000000000000, 4'h0, 4'h8, 4'd13}  // R13
   };

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      in_valid   = 1'b1;
      in_sign    = v.sg;
      in_exp     = v.ex;
      in_sig     = v.sig;
      in_guard   = v.g;
      in_sticky  = v.s;
      in_invalid = v.inv;
      in_rmode   = v.rm;
      in_trap_en = v.ten;
   endtask

   task automatic expect_vec(input vec_t v, input int idx);
      string tag;
      tag = $sformatf("R%0d/v%0d", v.req, idx);
      chk(tag, "valid",  {63'd0, out_valid}, 64'd1);
      chk(tag, "result", out_result, v.res);
      chk(tag, "flags",  {60'd0, out_flags}, {60'd0, v.fl});
      chk(tag, "trap",   {60'd0, out_trap},  {60'd0, v.tr});
   endtask

   initial begin
      // R1: outputs held at zero during reset
      @(negedge clk);
      chk("R1", "reset valid",  {63'd0, out_valid}, 64'd0);
      chk("R1", "reset result", out_result, 64'd0);
      chk("R1", "reset flags",  {56'd0, out_flags, out_trap}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: drive at one falling edge, the register captures at the
      // next rising edge, sample at the following falling edge
      for (int i = 0; i < NV; i++) begin
         drive(VTAB[i]);
         @(negedge clk);
         expect_vec(VTAB[i], i);
      end

      // R1: back-to-back stream, each result one cycle after its operands
      drive(VTAB[0]);
      @(negedge clk);
      expect_vec(VTAB[0], 0);
      drive(VTAB[9]);
      @(negedge clk);
      expect_vec(VTAB[9], 9);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R1", "idle valid",  {63'd0, out_valid}, 64'd0);
      chk("R1", "idle result", out_result, 64'd0);

      // R1: reset during traffic clears the outputs
      drive(VTAB[3]);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "midreset valid", {63'd0, out_valid}, 64'd0);
      chk("R1", "midreset flags", {56'd0, out_flags, out_trap}, 64'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: inexact trap enabled on an overflow without overflow trap
      drive('{1'b0, 14'sd2047, M1, 1'b0,1'b0,1'b0, 2'd0, 4'h1,
              64'h7FF0000000000000, 4'h4, 4'h1, 4'd12});
      @(negedge clk);
      chk("R12", "ovf+inx trap flags", {60'd0, out_flags}, 64'h4);
      chk("R12", "ovf+inx trap trap",  {60'd0, out_trap},  64'h1);
      in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule